// File: doc/BRIEF.md
# Parallel Display Bus Master (8-bit, strobed)

This block sits between a host command port and the 8-bit parallel bus of a TFT display controller. The bus has a chip select, a line that tells commands from data, separate active-low write and read strobes, a display reset, and a shared data bus driven through an output enable. The host hands the block one operation at a time: a command byte or word, a data byte or word, a pixel value repeated a given number of times, a 32-bit register read, or a single pixel read from graphics RAM. The block turns each operation into correctly timed strobes. Any read result comes back as a one-cycle response pulse.

After reset the block runs the display power-up sequence on its own and accepts no command until it is finished. Reads always begin with one discarded strobe. A pixel read returns red, green and blue bytes, each carrying 6 significant bits in its upper end, and the block packs them into a 16-bit 5-6-5 colour. Strobe phase widths and the power-up delays are parameters counted in clock cycles. With a 50 MHz clock the defaults are about 15 ms, 2 ms and 100 ms.

The command port is valid/ready. The block samples an operation only in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only when the block is idle, so holding `cmd_valid` high while the block is busy is the back-pressure case and is always safe. The response port has no ready: `rsp_valid` is a single-cycle pulse that the host must take when it appears.

Top module: `lcdb_master`

## Requirements
- R1: After `rst` is released, `lcd_rst_n`, `lcd_cs_n`, `lcd_dc`, `lcd_wr_n` and `lcd_rd_n` are high and `cmd_ready` is low. `lcd_rst_n` falls on the PRE_CYC-th rising clock edge after the last edge at which `rst` is sampled high, and stays low for exactly RST_CYC cycles. `cmd_ready` rises exactly POST_CYC cycles after `lcd_rst_n` rises.
- R2: For every byte written, the byte is on `lcd_db_out` with `lcd_db_oe` high and `lcd_wr_n` high for at least one cycle before `lcd_wr_n` falls. The byte stays unchanged while `lcd_wr_n` is low, `lcd_wr_n` stays low for exactly LO_CYC cycles, and `lcd_cs_n` is low throughout.
- R3: Command operations drive `lcd_dc` low during their write strobes. Op code 0 writes `cmd_arg[7:0]`. Op code 2 writes `cmd_arg[15:8]` and then `cmd_arg[7:0]`. `lcd_dc` is high again once the operation completes.
- R4: Data operations drive `lcd_dc` high. Op code 1 writes `cmd_arg[7:0]`. Op code 3 writes `cmd_arg[15:8]` and then `cmd_arg[7:0]`.
- R5: Fill (op code 4) writes `cmd_arg` `cmd_count` times, high byte then low byte each time, with a fresh write strobe for every byte even though the value repeats. A `cmd_count` of 0 produces no strobe and leaves the block ready.
- R6: Every read sequence has `lcd_db_oe` low for at least one cycle before the first fall of `lcd_rd_n`, keeps it low for all read strobes, and sets it high again when the sequence completes. The byte captured on the first read strobe is discarded.
- R7: Register read (op code 5) writes `cmd_arg[7:0]` as a command. It then issues five read strobes with `lcd_dc` high and returns bytes 2 to 5, first received in bits 31:24, on `rsp_data`. Before `rsp_valid`, `lcd_cs_n` goes high for exactly HI_CYC cycles and then low again.
- R8: Pixel read (op code 6) issues no write and four read strobes. Bytes 2, 3 and 4 are red R, green G and blue B, and `rsp_data` is `{16'h0, R[7:3], G[7:2], B[7:3]}`.
- R9: `cmd_ready` is high only when idle and is low in the cycle after an operation that causes bus activity is accepted. Each read operation produces exactly one single-cycle `rsp_valid` pulse, and write operations produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host offers an operation |
| cmd_ready | output | 1 | Block is idle and takes the operation |
| cmd_op | input | 3 | Operation code (0 to 6, see requirements) |
| cmd_arg | input | 16 | Command, data word, fill value or register number |
| cmd_count | input | CNT_W | Repetition count for fill |
| rsp_valid | output | 1 | One-cycle pulse: read result valid |
| rsp_data | output | 32 | Register value or 5-6-5 pixel |
| lcd_rst_n | output | 1 | Display reset, active low |
| lcd_cs_n | output | 1 | Display chip select, active low |
| lcd_dc | output | 1 | Low for command, high for data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_db_out | output | 8 | Data bus output value |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db_in | input | 8 | Data bus input value |

## Verification
The assertions take for granted that the host uses only op codes 0 to 6. They also assume that the display holds `lcd_db_in` steady from the fall of a read strobe until the block captures it at the end of the low phase. The bench keeps to both rules. Its display model changes `lcd_db_in` only on the falling edge of `lcd_rd_n`, and every operation it issues comes from a fixed table or a directed test.

// File: rtl/lcdb_pkg.sv
`timescale 1ns/1ps
package lcdb_pkg;
  localparam int BUS_W = 8;
  localparam int RD_REG_STROBES = 5;
  localparam int RD_PIX_STROBES = 4;

  // output colour channel layout: red, green, blue
  localparam int CH_W   [3] = '{5, 6, 5};
  localparam int CH_LSB [3] = '{11, 5, 0};

  typedef enum logic [2:0] {
    OP_CMD8   = 3'd0,
    OP_DATA8  = 3'd1,
    OP_CMD16  = 3'd2,
    OP_DATA16 = 3'd3,
    OP_FILL   = 3'd4,
    OP_RDREG  = 3'd5,
    OP_RDPIX  = 3'd6
  } lcdb_op_e;

  typedef enum logic [3:0] {
    ST_PWR_PRE, ST_PWR_RST, ST_PWR_POST, ST_IDLE,
    ST_WSET, ST_WLO, ST_WHI,
    ST_TURN, ST_RLO, ST_RHI,
    ST_CSHI, ST_DONE
  } lcdb_st_e;
endpackage

// File: rtl/lcdb_timer.sv
`timescale 1ns/1ps
module lcdb_timer #(
  parameter int TW = 8,
  parameter logic [TW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= INIT;
    else if (load)         cnt_q <= val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lcdb_rgb565.sv
`timescale 1ns/1ps
module lcdb_rgb565
  import lcdb_pkg::*;
(
  input  logic [23:0] raw,
  output logic [15:0] rgb
);
  for (genvar c = 0; c < 3; c++) begin : g_ch
    localparam int SRC_LSB = 8 * (2 - c) + 8 - CH_W[c];
    assign rgb[CH_LSB[c] +: CH_W[c]] = raw[SRC_LSB +: CH_W[c]];
  end
endmodule

// File: rtl/lcdb_seq.sv
`timescale 1ns/1ps
module lcdb_seq
  import lcdb_pkg::*;
#(
  parameter int LO_CYC   = 2,
  parameter int HI_CYC   = 2,
  parameter int PRE_CYC  = 750000,
  parameter int RST_CYC  = 100000,
  parameter int POST_CYC = 5000000,
  parameter int CNT_W    = 16,
  parameter int TW       = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [15:0]      cmd_arg,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             rsp_valid,
  output logic             is_pix,
  output logic [31:0]      acc,
  output logic             tm_load,
  output logic [TW-1:0]    tm_val,
  input  logic             tm_zero,
  output logic             lcd_rst_n,
  output logic             lcd_cs_n,
  output logic             lcd_dc,
  output logic             lcd_wr_n,
  output logic             lcd_rd_n,
  output logic [BUS_W-1:0] lcd_db_out,
  output logic             lcd_db_oe,
  input  logic [BUS_W-1:0] lcd_db_in
);
  localparam logic [TW-1:0] T_LO   = TW'(LO_CYC - 1);
  localparam logic [TW-1:0] T_HI   = TW'(HI_CYC - 1);
  localparam logic [TW-1:0] T_RST  = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] T_POST = TW'(POST_CYC - 1);

  lcdb_st_e         st_q, st_d;
  lcdb_op_e         op_q;
  lcdb_op_e         op_in;
  logic [15:0]      arg_q, wsh_q;
  logic             nb_q;
  logic [CNT_W-1:0] rep_q;
  logic [2:0]       rcnt_q;
  logic [31:0]      acc_q;
  logic             dc_q, wr_n_q, rd_n_q, rst_n_q, cs_n_q, oe_q;

  assign op_in = lcdb_op_e'(cmd_op);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_PWR_PRE:  if (tm_zero) st_d = ST_PWR_RST;
      ST_PWR_RST:  if (tm_zero) st_d = ST_PWR_POST;
      ST_PWR_POST: if (tm_zero) st_d = ST_IDLE;
      ST_IDLE: if (cmd_valid) begin
        case (op_in)
          OP_CMD8, OP_DATA8, OP_CMD16, OP_DATA16, OP_RDREG: st_d = ST_WSET;
          OP_FILL:  st_d = (cmd_count == '0) ? ST_IDLE : ST_WSET;
          OP_RDPIX: st_d = ST_TURN;
          default:  st_d = ST_IDLE;
        endcase
      end
      ST_WSET: st_d = ST_WLO;
      ST_WLO:  if (tm_zero) st_d = ST_WHI;
      ST_WHI:  if (tm_zero) begin
        if (nb_q)                                         st_d = ST_WSET;
        else if (op_q == OP_FILL && rep_q > CNT_W'(1))    st_d = ST_WSET;
        else if (op_q == OP_RDREG)                        st_d = ST_TURN;
        else                                              st_d = ST_IDLE;
      end
      ST_TURN: st_d = ST_RLO;
      ST_RLO:  if (tm_zero) st_d = ST_RHI;
      ST_RHI:  if (tm_zero) begin
        if (rcnt_q > 3'd1)          st_d = ST_RLO;
        else if (op_q == OP_RDREG)  st_d = ST_CSHI;
        else                        st_d = ST_DONE;
      end
      ST_CSHI: if (tm_zero) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign tm_load = (st_d != st_q);
  always_comb begin
    case (st_d)
      ST_PWR_RST:             tm_val = T_RST;
      ST_PWR_POST:            tm_val = T_POST;
      ST_WLO, ST_RLO:         tm_val = T_LO;
      ST_WHI, ST_RHI, ST_CSHI: tm_val = T_HI;
      default:                tm_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_PWR_PRE;
      op_q   <= OP_CMD8;
      arg_q  <= '0;
      wsh_q  <= '0;
      nb_q   <= 1'b0;
      rep_q  <= '0;
      rcnt_q <= '0;
      acc_q  <= '0;
      dc_q   <= 1'b1;
    end else begin
      st_q <= st_d;
      case (st_q)
        ST_IDLE: if (cmd_valid) begin
          op_q   <= op_in;
          arg_q  <= cmd_arg;
          rep_q  <= cmd_count;
          dc_q   <= !(op_in == OP_CMD8 || op_in == OP_CMD16 || op_in == OP_RDREG);
          nb_q   <= (op_in == OP_CMD16 || op_in == OP_DATA16 || op_in == OP_FILL);
          wsh_q  <= (op_in == OP_CMD16 || op_in == OP_DATA16 || op_in == OP_FILL)
                    ? cmd_arg : {cmd_arg[7:0], 8'h00};
          rcnt_q <= (op_in == OP_RDREG) ? 3'(RD_REG_STROBES) : 3'(RD_PIX_STROBES);
        end
        ST_WHI: if (tm_zero) begin
          if (nb_q) begin
            wsh_q <= {wsh_q[7:0], 8'h00};
            nb_q  <= 1'b0;
          end else if (op_q == OP_FILL && rep_q > CNT_W'(1)) begin
            rep_q <= rep_q - 1'b1;
            wsh_q <= arg_q;
            nb_q  <= 1'b1;
          end else begin
            dc_q <= 1'b1;
          end
        end
        ST_RLO: if (tm_zero) acc_q <= {acc_q[23:0], lcd_db_in};
        ST_RHI: if (tm_zero) rcnt_q <= rcnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  // bus pins registered from the next state so they never glitch
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_q <= 1'b1; rd_n_q <= 1'b1; rst_n_q <= 1'b1; cs_n_q <= 1'b1; oe_q <= 1'b1;
    end else begin
      wr_n_q  <= (st_d != ST_WLO);
      rd_n_q  <= (st_d != ST_RLO);
      rst_n_q <= (st_d != ST_PWR_RST);
      cs_n_q  <= (st_d == ST_PWR_PRE || st_d == ST_PWR_RST ||
                  st_d == ST_PWR_POST || st_d == ST_CSHI);
      oe_q    <= !(st_d == ST_TURN || st_d == ST_RLO ||
                   st_d == ST_RHI  || st_d == ST_CSHI);
    end
  end

  assign cmd_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = (st_q == ST_DONE);
  assign is_pix     = (op_q == OP_RDPIX);
  assign acc        = acc_q;
  assign lcd_dc     = dc_q;
  assign lcd_wr_n   = wr_n_q;
  assign lcd_rd_n   = rd_n_q;
  assign lcd_rst_n  = rst_n_q;
  assign lcd_cs_n   = cs_n_q;
  assign lcd_db_oe  = oe_q;
  assign lcd_db_out = wsh_q[15:8];

  AST_RST_PARKED: assert property (@(posedge clk) disable iff (rst)
    !lcd_rst_n |-> (lcd_cs_n && lcd_dc && lcd_wr_n && lcd_rd_n && !cmd_ready)); // R1
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_wr_n) |-> $stable(lcd_db_out)); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n && $past(!lcd_wr_n)) |-> $stable(lcd_db_out)); // R2
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !lcd_wr_n |-> (lcd_db_oe && !lcd_cs_n)); // R2
  AST_OE_BEFORE_RD: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_rd_n) |-> $past(!lcd_db_oe)); // R6
  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !lcd_rd_n |-> (!lcd_db_oe && lcd_dc && lcd_wr_n)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9
  AST_RSP_SELECTED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!lcd_cs_n && lcd_rd_n && !cmd_ready)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (lcd_wr_n && lcd_rd_n && lcd_db_oe)); // R9
  AST_OP_KNOWN: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |-> (cmd_op != 3'd7)); // R9
endmodule

// File: rtl/lcdb_master.sv
`timescale 1ns/1ps
module lcdb_master
  import lcdb_pkg::*;
#(
  parameter int LO_CYC   = 2,
  parameter int HI_CYC   = 2,
  parameter int PRE_CYC  = 750000,
  parameter int RST_CYC  = 100000,
  parameter int POST_CYC = 5000000,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [15:0]      cmd_arg,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             lcd_rst_n,
  output logic             lcd_cs_n,
  output logic             lcd_dc,
  output logic             lcd_wr_n,
  output logic             lcd_rd_n,
  output logic [7:0]       lcd_db_out,
  output logic             lcd_db_oe,
  input  logic [7:0]       lcd_db_in
);
  localparam int MAX_AB  = (PRE_CYC > RST_CYC) ? PRE_CYC : RST_CYC;
  localparam int MAX_ABC = (MAX_AB > POST_CYC) ? MAX_AB : POST_CYC;
  localparam int MAX_PH  = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int MAX_ALL = (MAX_ABC > MAX_PH) ? MAX_ABC : MAX_PH;
  localparam int TW      = $clog2(MAX_ALL + 1);
  localparam logic [TW-1:0] T_PRE = TW'(PRE_CYC - 1);

  logic          tm_load, tm_zero, is_pix;
  logic [TW-1:0] tm_val;
  logic [31:0]   acc;
  logic [15:0]   pix565;

  lcdb_timer #(.TW(TW), .INIT(T_PRE)) i_timer (
    .clk(clk), .rst(rst), .load(tm_load), .val(tm_val), .zero(tm_zero)
  );

  lcdb_seq #(
    .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .PRE_CYC(PRE_CYC), .RST_CYC(RST_CYC),
    .POST_CYC(POST_CYC), .CNT_W(CNT_W), .TW(TW)
  ) i_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_count(cmd_count),
    .rsp_valid(rsp_valid), .is_pix(is_pix), .acc(acc),
    .tm_load(tm_load), .tm_val(tm_val), .tm_zero(tm_zero),
    .lcd_rst_n(lcd_rst_n), .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc),
    .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_db_out(lcd_db_out),
    .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
  );

  lcdb_rgb565 i_rgb (.raw(acc[23:0]), .rgb(pix565));

  assign rsp_data = is_pix ? {16'h0000, pix565} : acc;
endmodule

// File: tb/test_lcdb_master.sv
`timescale 1ns/1ps
module test_lcdb_master;
  localparam int LO = 2, HI = 2, PRE = 40, RSTC = 20, POST = 60, CW = 8;
  localparam int PER = 20;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [15:0] cmd_arg = 0;
  logic [CW-1:0] cmd_count = 0;
  logic cmd_ready, rsp_valid, lcd_rst_n, lcd_cs_n, lcd_dc, lcd_wr_n, lcd_rd_n, lcd_db_oe;
  logic [31:0] rsp_data;
  logic [7:0] lcd_db_out;
  logic [7:0] lcd_db_in = 0;

  always #(PER/2) clk = ~clk;

  lcdb_master #(.LO_CYC(LO), .HI_CYC(HI), .PRE_CYC(PRE), .RST_CYC(RSTC),
                .POST_CYC(POST), .CNT_W(CW)) i_lcdb_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_count(cmd_count),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .lcd_rst_n(lcd_rst_n),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe), .lcd_db_in(lcd_db_in)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // display model
  bit armed = 0;
  logic [7:0] wl_dat [64];
  logic       wl_dc  [64];
  int wl_n = 0, w_bad = 0, w_cs_bad = 0;
  longint t_wf = 0;
  always @(negedge lcd_wr_n) t_wf = $time;
  always @(posedge lcd_wr_n) if (armed) begin
    if ($time - t_wf != LO * PER) w_bad++;
    if (lcd_cs_n !== 1'b0) w_cs_bad++;
    if (wl_n < 64) begin wl_dat[wl_n] = lcd_db_out; wl_dc[wl_n] = lcd_dc; end
    wl_n++;
  end

  logic [7:0] rd_bytes [8];
  int rd_idx = 0, oe_bad = 0, rd_dc_bad = 0;
  logic oe_prev = 1;
  always @(negedge clk) oe_prev <= lcd_db_oe;
  always @(negedge lcd_rd_n) if (armed) begin
    if (oe_prev !== 1'b0 || lcd_db_oe !== 1'b0) oe_bad++;
    if (lcd_dc !== 1'b1) rd_dc_bad++;
    lcd_db_in <= rd_bytes[rd_idx[2:0]];
    rd_idx++;
  end

  int cs_rise = 0;
  longint t_csr = 0, cs_w = 0;
  always @(posedge lcd_cs_n) if (armed) begin cs_rise++; t_csr = $time; end
  always @(negedge lcd_cs_n) if (armed && cs_rise > 0) cs_w = $time - t_csr;

  int rsp_cnt = 0;
  logic [31:0] rsp_last = 0;
  always @(negedge clk) if (rsp_valid === 1'b1) begin rsp_cnt++; rsp_last = rsp_data; end

  longint t_rf = 0, t_rr = 0, t_rdy = 0;
  int rst_falls = 0;
  always @(negedge lcd_rst_n) begin t_rf = $time; rst_falls++; end
  always @(posedge lcd_rst_n) t_rr = $time;
  always @(posedge cmd_ready) if (t_rdy == 0 && !rst) t_rdy = $time;

  task automatic send(logic [2:0] op, logic [15:0] arg, logic [CW-1:0] cnt);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_arg = arg; cmd_count = cnt;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_logs();
    wl_n = 0; rd_idx = 0; rsp_cnt = 0; cs_rise = 0; cs_w = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // write vectors: {op, arg, count}
  localparam logic [26:0] VEC [7] = '{
    {3'd0, 16'h002C, 8'd0},
    {3'd1, 16'h00A5, 8'd0},
    {3'd2, 16'h1234, 8'd0},
    {3'd3, 16'hBEEF, 8'd0},
    {3'd4, 16'hF81F, 8'd3},
    {3'd4, 16'h0707, 8'd1},
    {3'd4, 16'h5555, 8'd0}
  };

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0, 3'd2: return "R3";
      3'd1, 3'd3: return "R4";
      default:    return "R5";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    longint t_last_hi;
    repeat (3) @(posedge clk);
    t_last_hi = $time;
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 parked state just after reset
    check("R1 ready low", {31'b0, cmd_ready}, 0);
    check("R1 lines parked", {27'b0, lcd_rst_n, lcd_cs_n, lcd_dc, lcd_wr_n, lcd_rd_n}, 32'h1F);
    while (!cmd_ready) @(negedge clk);
    check("R1 reset fall time", 32'(t_rf - t_last_hi), PRE * PER);
    check("R1 reset low width", 32'(t_rr - t_rf), RSTC * PER);
    check("R1 ready after post wait", 32'(t_rdy - t_rr), POST * PER);
    check("R1 single reset pulse", rst_falls, 1);
    armed = 1;
    repeat (2) @(negedge clk);

    foreach (VEC[k]) begin
      logic [2:0]  op;
      logic [15:0] arg;
      logic [7:0]  cnt;
      int          nexp;
      logic        dexp;
      {op, arg, cnt} = VEC[k];
      nexp = (op == 3'd0 || op == 3'd1) ? 1 : (op == 3'd4) ? 2 * cnt : 2;
      dexp = !(op == 3'd0 || op == 3'd2);
      clear_logs();
      send(op, arg, cnt);
      wait_idle();
      check({req_of(op), " strobe count"}, wl_n, nexp);
      for (int b = 0; b < nexp && b < 64; b++) begin
        logic [7:0] be;
        be = (nexp == 1) ? arg[7:0] : (b % 2 == 0) ? arg[15:8] : arg[7:0];
        check({req_of(op), " byte"}, {23'b0, wl_dc[b], wl_dat[b]}, {23'b0, dexp, be});
      end
      check({req_of(op), " dc high after"}, {31'b0, lcd_dc}, 1);
      check("R9 no response on write", rsp_cnt, 0);
    end

    // R9 busy while operating
    clear_logs();
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd1; cmd_arg = 16'h003C;
    @(negedge clk);
    cmd_valid = 0;
    check("R9 ready low when busy", {31'b0, cmd_ready}, 0);
    wait_idle();
    check("R4 busy-case byte", {24'b0, wl_dat[0]}, 32'h3C);

    // R7 register read
    clear_logs();
    rd_bytes[0] = 8'h5A; rd_bytes[1] = 8'hDE; rd_bytes[2] = 8'hAD;
    rd_bytes[3] = 8'h01; rd_bytes[4] = 8'h7F;
    send(3'd5, 16'h0004, 0);
    wait_idle();
    check("R7 command write count", wl_n, 1);
    check("R7 command byte and dc", {23'b0, wl_dc[0], wl_dat[0]}, 32'h004);
    check("R7 read strobes", rd_idx, 5);
    check("R7 dc high on reads", rd_dc_bad, 0);
    check("R6 oe low before reads", oe_bad, 0);
    check("R7 cs pulse count", cs_rise, 1);
    check("R7 cs pulse width", 32'(cs_w), HI * PER);
    check("R7 response count", rsp_cnt, 1);
    check("R7 register value", rsp_last, 32'hDEAD017F);
    check("R6 oe restored", {31'b0, lcd_db_oe}, 1);

    // R8 pixel reads
    clear_logs();
    rd_bytes[0] = 8'h77; rd_bytes[1] = 8'hFC; rd_bytes[2] = 8'h84; rd_bytes[3] = 8'h08;
    send(3'd6, 16'h0000, 0);
    wait_idle();
    check("R8 no write", wl_n, 0);
    check("R8 read strobes", rd_idx, 4);
    check("R8 pixel A", rsp_last, 32'h0000FC21);
    check("R9 one response", rsp_cnt, 1);
    check("R8 no cs pulse", cs_rise, 0);

    clear_logs();
    rd_bytes[0] = 8'h11; rd_bytes[1] = 8'h48; rd_bytes[2] = 8'hA8; rd_bytes[3] = 8'h9C;
    send(3'd6, 16'h0000, 0);
    wait_idle();
    check("R8 pixel B", rsp_last, 32'h00004D53);
    check("R6 oe before reads pix", oe_bad, 0);
    check("R6 oe restored pix", {31'b0, lcd_db_oe}, 1);

    check("R2 strobe low width", w_bad, 0);
    check("R2 cs low on writes", w_cs_bad, 0);
    finish_run();
  end
endmodule